// File: doc/BRIEF.md
# EEPROM Word Address Counter

This block keeps the byte address that a serial EEPROM uses for its next data transfer. The address survives from one bus transaction to the next, so a read that carries no address picks up one past the last byte touched. A bus front end, which is not part of this block, pulses a load strobe when it has collected the page-select bits from the device address byte and the following word address byte. It pulses a step strobe after each data byte moves, and it says whether that byte was written or read.

The two directions wrap in different ways. A write step advances only the offset bits inside the current page. A burst that runs past the end of the page therefore comes back to the first byte of the same page. A read step advances the whole address, so it walks across page boundaries and falls from the top of the array back to byte zero. The array width, the page width and the number of page-select bits are all parameters. The default is a 2048-byte array with 16-byte pages and three page-select bits. An 8-bit array with 8-byte pages is the small variant.

Top module: `eep_word_ptr`

## Requirements
- R1: While the active-low reset `rst_n` is low, and on the first cycle after it is released, `addr_o` is zero.
- R2: A cycle with `load_i` high sets `addr_o`, one clock later, to the page-select bits placed above the 8-bit word byte (`{dev_page_i, word_i}`), keeping only the low `ADDR_W` bits.
- R3: When `load_i` and `incr_i` are both high in one cycle, the load value is taken and no step is applied.
- R4: With `load_i` and `incr_i` both low, `addr_o` keeps its value.
- R5: A write step (`incr_i` high, `is_write_i` high) adds one to the low `PAGE_W` bits of `addr_o`, modulo the page size, and leaves bits `ADDR_W-1` down to `PAGE_W` unchanged.
- R6: A write step taken at the last byte of a page (all low `PAGE_W` bits set) returns `addr_o` to the first byte of that same page.
- R7: A read step (`incr_i` high, `is_write_i` low) adds one to the whole address, carrying into the page bits.
- R8: A read step taken at the highest address (all `ADDR_W` bits set) gives address zero.
- R9: The page size is 2^`PAGE_W`. After 16 write steps with 16-byte pages, or 8 write steps with 8-byte pages, the address is back at the starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Take a new address from `dev_page_i` and `word_i` |
| dev_page_i | input | DEV_PAGE_W | Page-select bits from the device address byte |
| word_i | input | 8 | Word address byte |
| incr_i | input | 1 | Step the address after one data byte |
| is_write_i | input | 1 | 1: the step follows a written byte; 0: a read byte |
| addr_o | output | ADDR_W | Current byte address |

## Verification
The bench drives write bursts that cross a page end and checks that the address returns to the start of the same page. A design that let the carry reach the row bits would move the burst into the next page and overwrite it. It runs reads that cross a page boundary and reads that start at the highest address. A design that used the page mask for reads would loop inside one page, and one with a wrong array width would skip address zero. It also applies load and step in the same cycle, to catch a design that gives the step priority, and it loads page bits into the 8-bit variant, where any bits above the array width must be dropped.

// File: rtl/eep_word_ptr_pkg.sv
package eep_word_ptr_pkg;

  // Width used for all address arithmetic. Callers narrow the result.
  localparam int MAX_W = 16;

  typedef logic [MAX_W-1:0] wide_addr_t;

  // Build the load address: page-select bits go above the word byte.
  function automatic wide_addr_t join_load(input wide_addr_t page, input logic [7:0] word);
    return (page << 8) | wide_addr_t'(word);
  endfunction

  // Read step: plain increment. The caller's truncation does the array wrap.
  function automatic wide_addr_t step_read(input wide_addr_t a);
    return a + wide_addr_t'(1);
  endfunction

  // Write step: increment only the bits under the page mask.
  function automatic wide_addr_t step_write(input wide_addr_t a, input int page_w);
    wide_addr_t pmask;
    pmask = (wide_addr_t'(1) << page_w) - wide_addr_t'(1);
    return (a & ~pmask) | ((a + wide_addr_t'(1)) & pmask);
  endfunction

endpackage

// File: rtl/eep_word_ptr_load.sv
module eep_word_ptr_load #(
  parameter int ADDR_W     = 11,
  parameter int DEV_PAGE_W = 3
) (
  input  logic [DEV_PAGE_W-1:0] dev_page_i,
  input  logic [7:0]            word_i,
  output logic [ADDR_W-1:0]     load_val_o
);
  import eep_word_ptr_pkg::*;

  wide_addr_t joined;

  // Any bits above ADDR_W are dropped by the narrowing cast.
  assign joined     = join_load(wide_addr_t'(dev_page_i), word_i);
  assign load_val_o = ADDR_W'(joined);

endmodule

// File: rtl/eep_word_ptr_step.sv
module eep_word_ptr_step #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic              incr_i,
  input  logic              is_write_i,
  output logic [ADDR_W-1:0] wr_next_o,
  output logic [ADDR_W-1:0] rd_next_o,
  output logic              wr_wrap_o,
  output logic              rd_wrap_o
);
  import eep_word_ptr_pkg::*;

  wide_addr_t cur_ext;
  wide_addr_t rd_ext;

  assign cur_ext   = wide_addr_t'(cur_i);
  assign rd_ext    = step_read(cur_ext);
  assign rd_next_o = ADDR_W'(rd_ext);
  assign rd_wrap_o = incr_i & ~is_write_i & (&cur_i);

  generate
    if (PAGE_W >= ADDR_W) begin : g_flat
      // One page covers the whole array, so both rules are the same.
      assign wr_next_o = rd_next_o;
      assign wr_wrap_o = incr_i & is_write_i & (&cur_i);
    end else begin : g_paged
      wide_addr_t wr_ext;
      assign wr_ext    = step_write(cur_ext, PAGE_W);
      assign wr_next_o = ADDR_W'(wr_ext);
      assign wr_wrap_o = incr_i & is_write_i & (&cur_i[PAGE_W-1:0]);
    end
  endgenerate

endmodule

// File: rtl/eep_word_ptr_reg.sv
module eep_word_ptr_reg #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              incr_i,
  input  logic              is_write_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic [ADDR_W-1:0] wr_next_i,
  input  logic [ADDR_W-1:0] rd_next_i,
  output logic [ADDR_W-1:0] addr_q
);

  logic [ADDR_W-1:0] nxt;

  // Priority: load, then step, then hold.
  always_comb begin
    if (load_i)      nxt = load_val_i;
    else if (incr_i) nxt = is_write_i ? wr_next_i : rd_next_i;
    else             nxt = addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= nxt;
  end

endmodule

// File: rtl/eep_word_ptr.sv
module eep_word_ptr #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_W     = 4,
  parameter int DEV_PAGE_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [DEV_PAGE_W-1:0] dev_page_i,
  input  logic [7:0]            word_i,
  input  logic                  incr_i,
  input  logic                  is_write_i,
  output logic [ADDR_W-1:0]     addr_o
);

  generate
    if (ADDR_W > eep_word_ptr_pkg::MAX_W || PAGE_W < 1 || ADDR_W < 1) begin : g_bad_cfg
      $error("eep_word_ptr: unsupported width parameters");
    end
  endgenerate

  // Internal events, named so that the bound checker can see them.
  logic [ADDR_W-1:0] load_val_w;
  logic [ADDR_W-1:0] wr_next_w;
  logic [ADDR_W-1:0] rd_next_w;
  logic              wr_wrap_w;
  logic              rd_wrap_w;

  eep_word_ptr_load #(.ADDR_W(ADDR_W), .DEV_PAGE_W(DEV_PAGE_W)) i_load (
    .dev_page_i (dev_page_i),
    .word_i     (word_i),
    .load_val_o (load_val_w)
  );

  eep_word_ptr_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_step (
    .cur_i      (addr_o),
    .incr_i     (incr_i),
    .is_write_i (is_write_i),
    .wr_next_o  (wr_next_w),
    .rd_next_o  (rd_next_w),
    .wr_wrap_o  (wr_wrap_w),
    .rd_wrap_o  (rd_wrap_w)
  );

  eep_word_ptr_reg #(.ADDR_W(ADDR_W)) i_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .incr_i     (incr_i),
    .is_write_i (is_write_i),
    .load_val_i (load_val_w),
    .wr_next_i  (wr_next_w),
    .rd_next_i  (rd_next_w),
    .addr_q     (addr_o)
  );

endmodule

// File: rtl/eep_word_ptr_chk.sv
module eep_word_ptr_chk #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_W     = 4,
  parameter int DEV_PAGE_W = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  load_i,
  input logic [DEV_PAGE_W-1:0] dev_page_i,
  input logic [7:0]            word_i,
  input logic                  incr_i,
  input logic                  is_write_i,
  input logic [ADDR_W-1:0]     addr_o,
  input logic                  wr_wrap_w,
  input logic                  rd_wrap_w
);

  AST_LOAD_TAKES_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> addr_o == ADDR_W'({$past(dev_page_i), $past(word_i)})); // R2

  AST_LOAD_BEATS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && incr_i) |=> addr_o == ADDR_W'({$past(dev_page_i), $past(word_i)})); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !incr_i) |=> $stable(addr_o)); // R4

  AST_READ_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && incr_i && !is_write_i) |=> addr_o == ADDR_W'($past(addr_o) + 1'b1)); // R7

  AST_READ_ARRAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_wrap_w && !load_i) |=> addr_o == '0); // R8

  generate
    if (PAGE_W < ADDR_W) begin : g_row
      AST_WRITE_ROW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && incr_i && is_write_i) |=>
          addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W])); // R5

      AST_WRITE_OFFSET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && incr_i && is_write_i) |=>
          addr_o[PAGE_W-1:0] == PAGE_W'($past(addr_o[PAGE_W-1:0]) + 1'b1)); // R5

      AST_WRITE_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_wrap_w && !load_i) |=> addr_o[PAGE_W-1:0] == '0); // R6
    end
  endgenerate

endmodule

bind eep_word_ptr eep_word_ptr_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DEV_PAGE_W(DEV_PAGE_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_i     (load_i),
  .dev_page_i (dev_page_i),
  .word_i     (word_i),
  .incr_i     (incr_i),
  .is_write_i (is_write_i),
  .addr_o     (addr_o),
  .wr_wrap_w  (wr_wrap_w),
  .rd_wrap_w  (rd_wrap_w)
);

// File: tb/test_eep_word_ptr.sv
`timescale 1ns/1ps
module test_eep_word_ptr;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [2:0]  dev_page_i = '0;
  logic [7:0]  word_i = '0;
  logic        incr_i = 1'b0;
  logic        is_write_i = 1'b0;
  logic [10:0] addr_a;
  logic [7:0]  addr_b;

  int    n_run = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;

  // Reference addresses: A is 2048 bytes with 16-byte pages,
  // B is 256 bytes with 8-byte pages.
  int ref_a = 0;
  int ref_b = 0;

  always #4 clk = ~clk;

  // Main configuration under test (default parameters).
  eep_word_ptr i_eep_word_ptr (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .dev_page_i(dev_page_i),
    .word_i(word_i), .incr_i(incr_i), .is_write_i(is_write_i), .addr_o(addr_a)
  );

  // Small variant: 8-bit array, 8-byte pages.
  eep_word_ptr #(.ADDR_W(8), .PAGE_W(3), .DEV_PAGE_W(3)) i_eep_word_ptr_small (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .dev_page_i(dev_page_i),
    .word_i(word_i), .incr_i(incr_i), .is_write_i(is_write_i), .addr_o(addr_b)
  );

  function automatic int model_next(int a, int size, int psize);
    if (load_i)          return (int'(dev_page_i) * 256 + int'(word_i)) % size;
    else if (!incr_i)    return a;
    else if (is_write_i) return (a / psize) * psize + ((a % psize) + 1) % psize;
    else                 return (a + 1) % size;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ref_a <= 0;
      ref_b <= 0;
    end else begin
      ref_a <= model_next(ref_a, 2048, 16);
      ref_b <= model_next(ref_b, 256, 8);
    end
  end

  task automatic check(string req, int got, int exp, string what);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  // Compare both instances with the model on every cycle, away from the edge.
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check(cur_req, int'(addr_a), ref_a, "cycle compare, large");
      check(cur_req, int'(addr_b), ref_b, "cycle compare, small");
    end
  end

  task automatic drive(bit ld, int pg, int wd, bit inc, bit wr);
    @(negedge clk);
    load_i     = ld;
    dev_page_i = 3'(pg);
    word_i     = 8'(wd);
    incr_i     = inc;
    is_write_i = wr;
  endtask

  task automatic idle();
    drive(1'b0, 0, 0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lfsr;
    int start_a;
    int start_b;
    // R1: reset holds zero.
    cur_req = "R1";
    @(negedge clk);
    cmp_on = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", int'(addr_a), 0, "in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(addr_a), 0, "after reset");
    check("R1", int'(addr_b), 0, "after reset, small");

    // R2: load joins the page bits and the word byte.
    cur_req = "R2";
    drive(1'b1, 5, 'h3C, 1'b0, 1'b0);
    idle();
    check("R2", int'(addr_a), 'h53C, "load large");
    check("R2", int'(addr_b), 'h3C, "load small drops page bits");

    // R4: idle cycles hold the value.
    cur_req = "R4";
    repeat (4) idle();
    check("R4", int'(addr_a), 'h53C, "hold");

    // R5: write steps move the offset only.
    cur_req = "R5";
    repeat (3) drive(1'b0, 0, 0, 1'b1, 1'b1);
    idle();
    check("R5", int'(addr_a), 'h53F, "write step");
    check("R5", int'(addr_b), 'h3F, "write step small");

    // R6: write past the page end wraps inside the page.
    cur_req = "R6";
    drive(1'b1, 2, 'hFD, 1'b0, 1'b0);
    repeat (4) drive(1'b0, 0, 0, 1'b1, 1'b1);
    idle();
    check("R6", int'(addr_a), 'h2F1, "page wrap large");
    check("R6", int'(addr_b), 'hF9, "page wrap small");

    // R9: a full page of write steps returns to the start.
    cur_req = "R9";
    drive(1'b1, 2, 'hFD, 1'b0, 1'b0);
    idle();
    start_a = int'(addr_a);
    start_b = int'(addr_b);
    repeat (8) drive(1'b0, 0, 0, 1'b1, 1'b1);
    idle();
    check("R9", int'(addr_b), start_b, "8 steps, 8-byte page");
    repeat (7) drive(1'b0, 0, 0, 1'b1, 1'b1);
    drive(1'b0, 0, 0, 1'b1, 1'b1);
    idle();
    check("R9", int'(addr_a), start_a, "16 steps, 16-byte page");

    // R7: reads carry across page boundaries.
    cur_req = "R7";
    drive(1'b1, 0, 'hFE, 1'b0, 1'b0);
    repeat (4) drive(1'b0, 0, 0, 1'b1, 1'b0);
    idle();
    check("R7", int'(addr_a), 'h102, "read crosses page");
    check("R7", int'(addr_b), 'h02, "read crosses top, small");

    // R8: read at the top address gives zero.
    cur_req = "R8";
    drive(1'b1, 7, 'hFF, 1'b0, 1'b0);
    drive(1'b0, 0, 0, 1'b1, 1'b0);
    idle();
    check("R8", int'(addr_a), 0, "array wrap");
    check("R8", int'(addr_b), 0, "array wrap small");

    // R3: load and step together, load wins.
    cur_req = "R3";
    drive(1'b1, 3, 'h47, 1'b1, 1'b1);
    idle();
    check("R3", int'(addr_a), 'h347, "load beats write step");
    drive(1'b1, 1, 'h10, 1'b1, 1'b0);
    idle();
    check("R3", int'(addr_a), 'h110, "load beats read step");

    // Mixed traffic against the model (R5 and R7 rules).
    cur_req = "R5/R7 mix";
    lfsr = 'h1ACE;
    for (int i = 0; i < 300; i++) begin
      lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 'hFFFF;
      drive((lfsr & 'h1F) == 0, lfsr >> 5, lfsr >> 8, (lfsr & 2) != 0, (lfsr & 4) != 0);
    end
    idle();
    idle();
    finish_run();
  end

endmodule